// File: doc/BRIEF.md
# Raster line interrupt generator

This block forms the single interrupt request that a video processor raises toward its CPU. Two events can set it. The first is the start of the vertical blanking interval. The second is a programmable raster line down-counter that expires after a chosen number of visible lines. Each event sets its own pending flag. The interrupt line is a level that stays high while any pending flag has its enable set. Software services the interrupt by reading the status port. That read returns the vertical-blank flag and two sprite flags taken from the sprite logic, and it clears every pending flag.

The line counter is loaded from an 8-bit reload register at the start of vertical blanking and again each time it expires. It counts down once per visible line. A value N therefore gives a request after every N+1 visible lines. Because the counter only reloads at expiry or at frame start, a register value written inside the handler waits one more interrupt before it takes effect.

Top module: `raster_irq_gen`

## Requirements
- R1: After reset the reload register holds 0xFF, no flag is pending, `irq` is low and `statusByte` is 0x00. With line interrupts enabled and no frame-start strobe, 192 visible lines raise no request.
- R2: With reload value N loaded at frame start, the line flag is set at the end of visible line N+1 and then again every N+1 visible lines.
- R3: A reload value of 0x00 sets the line flag at the end of every visible line.
- R4: A reload value of 0xFF never sets the line flag within a 192-line frame.
- R5: A value written to the reload register is used only from the next counter expiry or frame start. Changing 20 to 5 right after the first request gives requests at visible lines 21, 42, 48, 54 and 60.
- R6: `statusByte` bit 7 is the pending vertical-blank flag. Bit 6 is the latched sprite-overflow flag and bit 5 the latched sprite-collision flag. Bits 4 to 0 read 0.
- R7: A `statusRead` strobe returns the current status byte and clears all four flags on the next clock edge. An event in the same cycle as the read still sets its flag.
- R8: `irq` = (line flag AND `lineIrqEn`) OR (vertical-blank flag AND `frameIrqEn`). A flag whose enable is off stays latched, and it drives `irq` once its enable is set.
- R9: Both sources may be enabled at once. Each source sets its own flag, and bit 7 tells the two apart.
- R10: Line ends with `lineActive` low leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineEnd | input | 1 | One-cycle strobe at each horizontal blank |
| lineActive | input | 1 | High when the line ending now is a visible line |
| frameEnd | input | 1 | One-cycle strobe at the start of vertical blanking |
| lineRegWr | input | 1 | Write strobe for the reload register |
| lineRegData | input | 8 | Reload value to write |
| lineIrqEn | input | 1 | Enable for line requests |
| frameIrqEn | input | 1 | Enable for vertical-blank requests |
| spriteOverflow | input | 1 | Sprite logic found nine or more sprites on a line |
| spriteCollision | input | 1 | Sprite logic found two sprites touching |
| statusRead | input | 1 | Status port read strobe, clears flags |
| statusByte | output | 8 | Status byte |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The hardest case to reach is the delayed reload. The register must change after the counter has already reloaded itself at an expiry, and before the next expiry. The stimulus does this by stepping lines one at a time. As soon as `irq` is seen, it writes the new value and reads the status port inside that gap, the way a handler would. It then counts lines to confirm that one more request still comes at the old spacing. A second hard case is a status read that falls in the same cycle as a line expiry. Here the stimulus drives both strobes on the same edge.

// File: rtl/rli_pkg.sv
package rli_pkg;

  // Strobes issued by the control unit to the datapath every cycle
  typedef struct packed {
    logic reload;     // load counter from reload register
    logic decrement;  // count one visible line
    logic lineHit;    // counter expired: set line flag
    logic frameHit;   // vertical blank started: set frame flag
    logic clearAll;   // status port read: clear flags
  } ctrlStrobes_t;

endpackage

// File: rtl/rli_ctrl.sv
module rli_ctrl
  import rli_pkg::*;
(
  input  logic         lineEnd,
  input  logic         lineActive,
  input  logic         frameEnd,
  input  logic         statusRead,
  input  logic         cntZero,
  output ctrlStrobes_t strobes
);

  logic lineStep;
  logic expire;

  // A visible line end advances the counter; frame start overrides it
  assign lineStep = lineEnd & lineActive & ~frameEnd;
  assign expire   = lineStep & cntZero;

  always_comb begin
    strobes.reload    = frameEnd | expire;
    strobes.decrement = lineStep & ~cntZero;
    strobes.lineHit   = expire;
    strobes.frameHit  = frameEnd;
    strobes.clearAll  = statusRead;
  end

endmodule

// File: rtl/rli_datapath.sv
module rli_datapath
  import rli_pkg::*;
#(
  parameter int          REG_W     = 8,
  parameter logic [REG_W-1:0] RESET_VAL = '1,
  parameter int          STATUS_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic                lineRegWr,
  input  logic [REG_W-1:0]    lineRegData,
  input  logic                lineIrqEn,
  input  logic                frameIrqEn,
  input  logic                spriteOverflow,
  input  logic                spriteCollision,
  output logic                cntZero,
  output logic [STATUS_W-1:0] statusByte,
  output logic                irq
);

  localparam int FRAME_BIT = STATUS_W - 1;
  localparam int OVF_BIT   = STATUS_W - 2;
  localparam int COL_BIT   = STATUS_W - 3;

  logic [REG_W-1:0] reloadReg;
  logic [REG_W-1:0] lineCnt;
  logic             lineFlag;
  logic             frameFlag;
  logic             ovfFlag;
  logic             colFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           reloadReg <= RESET_VAL;
    else if (lineRegWr)  reloadReg <= lineRegData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lineCnt <= RESET_VAL;
    else if (strobes.reload)    lineCnt <= reloadReg;
    else if (strobes.decrement) lineCnt <= lineCnt - 1'b1;
  end

  assign cntZero = (lineCnt == '0);

  // Sticky flags: a setting event wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineFlag  <= 1'b0;
      frameFlag <= 1'b0;
      ovfFlag   <= 1'b0;
      colFlag   <= 1'b0;
    end else begin
      lineFlag  <= strobes.lineHit  | (lineFlag  & ~strobes.clearAll);
      frameFlag <= strobes.frameHit | (frameFlag & ~strobes.clearAll);
      ovfFlag   <= spriteOverflow   | (ovfFlag   & ~strobes.clearAll);
      colFlag   <= spriteCollision  | (colFlag   & ~strobes.clearAll);
    end
  end

  always_comb begin
    statusByte            = '0;
    statusByte[FRAME_BIT] = frameFlag;
    statusByte[OVF_BIT]   = ovfFlag;
    statusByte[COL_BIT]   = colFlag;
  end

  assign irq = (lineFlag & lineIrqEn) | (frameFlag & frameIrqEn);

endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import rli_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineEnd,
  input  logic                lineActive,
  input  logic                frameEnd,
  input  logic                lineRegWr,
  input  logic [REG_W-1:0]    lineRegData,
  input  logic                lineIrqEn,
  input  logic                frameIrqEn,
  input  logic                spriteOverflow,
  input  logic                spriteCollision,
  input  logic                statusRead,
  output logic [STATUS_W-1:0] statusByte,
  output logic                irq
);

  ctrlStrobes_t strobes;
  logic         cntZero;

  rli_ctrl u_ctrl (
    .lineEnd    (lineEnd),
    .lineActive (lineActive),
    .frameEnd   (frameEnd),
    .statusRead (statusRead),
    .cntZero    (cntZero),
    .strobes    (strobes)
  );

  rli_datapath #(
    .REG_W     (REG_W),
    .RESET_VAL ({REG_W{1'b1}}),
    .STATUS_W  (STATUS_W)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .lineRegWr       (lineRegWr),
    .lineRegData     (lineRegData),
    .lineIrqEn       (lineIrqEn),
    .frameIrqEn      (frameIrqEn),
    .spriteOverflow  (spriteOverflow),
    .spriteCollision (spriteCollision),
    .cntZero         (cntZero),
    .statusByte      (statusByte),
    .irq             (irq)
  );

endmodule

// File: rtl/raster_irq_checker.sv
module raster_irq_checker #(
  parameter int STATUS_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                lineEnd,
  input logic                frameEnd,
  input logic                lineIrqEn,
  input logic                frameIrqEn,
  input logic                spriteOverflow,
  input logic                spriteCollision,
  input logic                statusRead,
  input logic [STATUS_W-1:0] statusByte,
  input logic                irq
);

  // R7: a read with no new event leaves irq low on the next cycle
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !lineEnd && !frameEnd) |=> !irq);

  // R8: with both enables off, irq stays low
  p_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!lineIrqEn && !frameIrqEn) |-> !irq);

  // R8: irq only rises after a timing strobe or an enable going high
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(lineEnd) || $past(frameEnd) ||
                    $rose(lineIrqEn) || $rose(frameIrqEn)));

  // R6: a frame-start strobe sets status bit 7
  p_frame_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> statusByte[STATUS_W-1]);

  // R6: status bit 7 only rises after a frame-start strobe
  p_frame_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[STATUS_W-1]) |-> $past(frameEnd));

  // R6: sprite inputs are captured into bits 6 and 5
  p_sprite_ovf_r6: assert property (@(posedge clk) disable iff (!rstN)
    spriteOverflow |=> statusByte[STATUS_W-2]);

  p_sprite_col_r6: assert property (@(posedge clk) disable iff (!rstN)
    spriteCollision |=> statusByte[STATUS_W-3]);

  // R6: low bits carry nothing
  p_low_bits_r6: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[STATUS_W-4:0] == '0);

endmodule

bind raster_irq_gen raster_irq_checker #(.STATUS_W(STATUS_W)) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .lineEnd         (lineEnd),
  .frameEnd        (frameEnd),
  .lineIrqEn       (lineIrqEn),
  .frameIrqEn      (frameIrqEn),
  .spriteOverflow  (spriteOverflow),
  .spriteCollision (spriteCollision),
  .statusRead      (statusRead),
  .statusByte      (statusByte),
  .irq             (irq)
);

// File: tb/raster_irq_gen_test.sv
module raster_irq_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineEnd = 1'b0;
  logic       lineActive = 1'b0;
  logic       frameEnd = 1'b0;
  logic       lineRegWr = 1'b0;
  logic [7:0] lineRegData = '0;
  logic       lineIrqEn = 1'b0;
  logic       frameIrqEn = 1'b0;
  logic       spriteOverflow = 1'b0;
  logic       spriteCollision = 1'b0;
  logic       statusRead = 1'b0;
  logic [7:0] statusByte;
  logic       irq;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  raster_irq_gen uut (
    .clk(clk), .rstN(rstN), .lineEnd(lineEnd), .lineActive(lineActive),
    .frameEnd(frameEnd), .lineRegWr(lineRegWr), .lineRegData(lineRegData),
    .lineIrqEn(lineIrqEn), .frameIrqEn(frameIrqEn),
    .spriteOverflow(spriteOverflow), .spriteCollision(spriteCollision),
    .statusRead(statusRead), .statusByte(statusByte), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All drives happen at the falling edge; results are sampled one falling edge later
  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    lineIrqEn = 1'b0; frameIrqEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] v);
    lineRegWr = 1'b1; lineRegData = v;
    @(negedge clk); lineRegWr = 1'b0;
  endtask

  task automatic frameStart();
    frameEnd = 1'b1;
    @(negedge clk); frameEnd = 1'b0;
  endtask

  task automatic stepLine(input logic active);
    lineEnd = 1'b1; lineActive = active;
    @(negedge clk); lineEnd = 1'b0; lineActive = 1'b0;
  endtask

  task automatic readStatus(output logic [7:0] s);
    s = statusByte;
    statusRead = 1'b1;
    @(negedge clk); statusRead = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    doReset();
    check("R1 irq after reset", irq, 0);
    check("R1 status after reset", statusByte, 8'h00);
    lineIrqEn = 1'b1;
    for (int k = 1; k <= 192; k++) begin
      stepLine(1'b1);
      if (irq) check("R1 no request from reset value", k, 0);
    end
    check("R1 irq after 192 lines", irq, 0);
    readStatus(s);
    check("R1 status after 192 lines", s, 8'h00);
  endtask

  task automatic t_period(input logic [7:0] n, input int lines, input string req);
    logic [7:0] s;
    doReset();
    lineIrqEn = 1'b1;
    writeReg(n);
    frameStart();
    readStatus(s);  // drop the frame flag
    for (int k = 1; k <= lines; k++) begin
      bit expIrq;
      stepLine(1'b1);
      expIrq = (n != 8'hFF) && ((k % (int'(n) + 1)) == 0);
      check(req, irq, int'(expIrq));
      if (irq) begin
        readStatus(s);
        check({req, " bit7 clear on line request"}, s[7], 0);
        check("R7 irq low after read", irq, 0);
      end
    end
  endtask

  task automatic t_delay();
    logic [7:0] s;
    doReset();
    lineIrqEn = 1'b1;
    writeReg(8'd20);
    frameStart();
    readStatus(s);
    for (int k = 1; k <= 60; k++) begin
      bit expIrq;
      stepLine(1'b1);
      expIrq = (k == 21) || (k == 42) || (k == 48) || (k == 54) || (k == 60);
      check("R5 delayed reload", irq, int'(expIrq));
      if (irq) begin
        if (k == 21) writeReg(8'd5);
        readStatus(s);
      end
    end
  endtask

  task automatic t_hold();
    logic [7:0] s;
    doReset();
    lineIrqEn = 1'b1;
    writeReg(8'd4);
    frameStart();
    readStatus(s);
    stepLine(1'b1); stepLine(1'b1);
    for (int k = 0; k < 10; k++) stepLine(1'b0);
    check("R10 no request during blank lines", irq, 0);
    stepLine(1'b1);
    check("R10 line 3 quiet", irq, 0);
    stepLine(1'b1);
    check("R10 line 4 quiet", irq, 0);
    stepLine(1'b1);
    check("R10 request at visible line 5", irq, 1);
  endtask

  task automatic t_status();
    logic [7:0] s;
    doReset();
    frameIrqEn = 1'b1;
    frameStart();
    check("R6 frame irq", irq, 1);
    check("R6 status frame only", statusByte, 8'h80);
    spriteOverflow = 1'b1; @(negedge clk); spriteOverflow = 1'b0;
    check("R6 overflow bit", statusByte, 8'hC0);
    spriteCollision = 1'b1; @(negedge clk); spriteCollision = 1'b0;
    check("R6 collision bit", statusByte, 8'hE0);
    readStatus(s);
    check("R7 read returns flags", s, 8'hE0);
    check("R7 status cleared", statusByte, 8'h00);
    check("R7 irq cleared", irq, 0);
  endtask

  task automatic t_mask();
    logic [7:0] s;
    doReset();
    writeReg(8'd0);
    frameStart();
    stepLine(1'b1);
    check("R8 disabled flags keep irq low", irq, 0);
    lineIrqEn = 1'b1;
    @(negedge clk);
    check("R8 latched line flag raises irq", irq, 1);
    lineIrqEn = 1'b0;
    frameIrqEn = 1'b1;
    @(negedge clk);
    check("R8 latched frame flag raises irq", irq, 1);
    readStatus(s);
    check("R8 read status", s, 8'h80);
    lineIrqEn = 1'b1;
    @(negedge clk);
    check("R8 cleared after read", irq, 0);
  endtask

  task automatic t_both();
    logic [7:0] s;
    doReset();
    lineIrqEn = 1'b1; frameIrqEn = 1'b1;
    writeReg(8'd1);
    frameStart();
    check("R9 frame request", irq, 1);
    readStatus(s);
    check("R9 frame source bit7", s, 8'h80);
    stepLine(1'b1);
    check("R9 line 1 quiet", irq, 0);
    stepLine(1'b1);
    check("R9 line request", irq, 1);
    readStatus(s);
    check("R9 line source bit7", s, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] s;
    doReset();
    lineIrqEn = 1'b1;
    writeReg(8'd0);
    frameStart();
    readStatus(s);
    lineEnd = 1'b1; lineActive = 1'b1; statusRead = 1'b1;
    @(negedge clk);
    lineEnd = 1'b0; lineActive = 1'b0; statusRead = 1'b0;
    check("R7 event beats same-cycle read", irq, 1);
  endtask

  initial begin
    t_reset();
    t_period(8'd3, 24, "R2 period N=3");
    t_period(8'd0, 10, "R3 every line");
    t_period(8'hFF, 192, "R4 disabled value");
    t_delay();
    t_hold();
    t_status();
    t_mask();
    t_both();
    t_race();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule